// File: doc/BRIEF.md
# Hibernate Wake-Up Access Controller

This block sits between a processor bus and a peripheral register domain that can be put to sleep. A local control register holds a two-bit power-mode field. Software writes the hibernate encoding to it while the domain is running, and the controller then treats the domain as asleep. The next bus read or write aimed at any domain register raises a wake request toward the analog side. The bus transfer is held with a wait signal until the analog side answers with a ready indication. That transfer then completes in the same cycle the ready is seen, carrying its normal data. A dummy read therefore works as a way to wake the domain.

Once the domain is awake, a settling interval starts. Its length is 110 µs counted in system clock cycles, rounded up from the clock frequency parameter. During this interval, converter start requests are refused. A refused request does not fire and is not held for later. Instead it raises a sticky error flag, which software reads and clears through the control register. The mode field keeps its hibernate value after wake-up until software writes the active encoding back.

The controller has four states:

- HIBERNATE: the domain is asleep.
- WAKING: the wake request is out.
- AWAKE_SETTLING: the settle timer is running.
- ACTIVE: normal operation.

It has four transitions:

- ACTIVE to HIBERNATE on a control write of the hibernate encoding.
- HIBERNATE to WAKING on any domain access.
- WAKING to AWAKE_SETTLING in the cycle the ready is seen.
- AWAKE_SETTLING to ACTIVE on the last count of the settle timer.

Top module: `hib_wake_ctrl`

## Requirements
- R1: A bus access to any address other than CTRL_ADDR while the controller is in HIBERNATE moves it to WAKING on the next clock edge, and wake_req stays high for as long as the controller is in WAKING.
- R2: The access that triggered a wake-up sees bus_wait high until the cycle in which wake_ready is high. In that cycle bus_wait is low and the transfer completes with the domain's normal read data or write effect. With ready arriving D cycles after wake_req rises, the access waits exactly D cycles.
- R3: The control register sits at address CTRL_ADDR. Bits [1:0] hold the mode field, where 2'b01 means active and 2'b10 means hibernate. After a wake-up the field still reads 2'b10 until software writes 2'b01.
- R4: The settle length is N = ceil(110 µs × CLK_HZ) cycles. A conversion start in any of the N cycles following the cycle in which ready was seen is refused. A conversion start in the cycle after those N cycles is accepted.
- R5: A refused conversion start produces no conv_go pulse, either at once or later, and sets conv_err, which stays high.
- R6: Control register bit 2 reads back conv_err. A control write with bit 2 set clears it.
- R7: A dummy read that wakes the domain returns the stored domain data and changes no domain register and no mode field.
- R8: After a synchronous active-low reset the controller is in ACTIVE with the settle timer expired. The mode field reads 2'b01, conv_err is 0, and a conversion start is accepted at once.
- R9: Writing 2'b10 to the mode field from ACTIVE enters HIBERNATE. Accesses to CTRL_ADDR never wait and never raise wake_req.
- R10: An accepted conversion start gives a one-cycle conv_go pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus transfer request, held until bus_wait is low |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, control register or domain data |
| bus_wait | output | 1 | Wait state, combinational from state |
| dom_sel | output | 1 | Domain transfer strobe |
| dom_write | output | 1 | Domain write direction |
| dom_addr | output | AW | Domain register address |
| dom_wdata | output | DW | Domain write data |
| dom_rdata | input | DW | Domain read data |
| wake_req | output | 1 | Wake request toward the analog side |
| wake_ready | input | 1 | Analog side reports wake-up complete |
| conv_start | input | 1 | Conversion start request |
| conv_go | output | 1 | Accepted conversion start pulse |
| conv_err | output | 1 | Sticky refused-start flag |

## Verification
The assertions check on every cycle the properties that hold whatever the stimulus is:
- A hibernating access always leads to WAKING.
- No domain strobe is issued before ready.
- The mode field still holds the hibernate code when settling begins.
- The timer counts down one per cycle, and ACTIVE never overlaps a running timer.
- conv_go never follows a cycle with an unexpired timer, and the error flag stays set.

Only the bench scenarios can show the rest: the exact number of wait cycles for a given wake delay, the one-cycle boundary between the last refused start and the first accepted one, the rounded settle length, and the fact that a dummy read leaves the domain contents untouched.

// File: rtl/hib_pkg.sv
package hib_pkg;

    typedef enum logic [1:0] {
        ST_HIBERNATE = 2'd0,
        ST_WAKING    = 2'd1,
        ST_SETTLING  = 2'd2,
        ST_ACTIVE    = 2'd3
    } hib_state_e;

    localparam logic [1:0] MODE_ACTIVE = 2'b01;
    localparam logic [1:0] MODE_HIB    = 2'b10;

endpackage

// File: rtl/hib_settle_timer.sv
module hib_settle_timer #(
    parameter int unsigned CYCLES = 11000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic last
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign busy = (cnt != '0);
    assign last = (cnt == CW'(1));

    // R4: the window shrinks by exactly one each cycle
    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (cnt == $past(cnt) - CW'(1)));

    // R4: a load always starts the full window
    assert_load_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == CW'(CYCLES)));

endmodule

// File: rtl/hib_wake_fsm.sv
module hib_wake_fsm
    import hib_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dom_acc,
    input  logic       hib_cmd,
    input  logic       wake_ready,
    input  logic       settle_last,
    output hib_state_e state,
    output logic       bus_wait,
    output logic       wake_req,
    output logic       settle_load,
    output logic       conv_ok
);

    hib_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACTIVE:    if (hib_cmd)     state_nx = ST_HIBERNATE;
            ST_HIBERNATE: if (dom_acc)     state_nx = ST_WAKING;
            ST_WAKING:    if (wake_ready)  state_nx = ST_SETTLING;
            ST_SETTLING:  if (settle_last) state_nx = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ACTIVE;
        else        state <= state_nx;
    end

    always_comb begin
        bus_wait    = 1'b0;
        wake_req    = 1'b0;
        settle_load = 1'b0;
        conv_ok     = 1'b0;
        unique case (state)
            ST_HIBERNATE: bus_wait = dom_acc;
            ST_WAKING: begin
                wake_req    = 1'b1;
                bus_wait    = dom_acc && !wake_ready;
                settle_load = wake_ready;
            end
            ST_SETTLING: ;
            ST_ACTIVE:   conv_ok = 1'b1;
        endcase
    end

    // R1: a domain access while asleep starts the wake-up
    assert_wake_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIBERNATE && dom_acc) |=> (state == ST_WAKING && wake_req));

    // R2: waking only ends when ready is seen
    assert_wake_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKING && !wake_ready) |=> (state == ST_WAKING));

    // R9: hibernation is only entered from ACTIVE by command
    assert_hib_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIBERNATE && $past(state) != ST_HIBERNATE) |->
            ($past(state) == ST_ACTIVE && $past(hib_cmd)));

endmodule

// File: rtl/hib_mode_conv.sv
module hib_mode_conv
    import hib_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [2:0] ctrl_wdata,
    input  logic       conv_start,
    input  logic       conv_ok,
    output logic [1:0] mode,
    output logic       conv_err,
    output logic       conv_go
);

    logic reject;
    assign reject = conv_start && !conv_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_ACTIVE;
        end else if (ctrl_wr) begin
            mode <= ctrl_wdata[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_err <= 1'b0;
        end else if (reject) begin
            conv_err <= 1'b1;
        end else if (ctrl_wr && ctrl_wdata[2]) begin
            conv_err <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) conv_go <= 1'b0;
        else        conv_go <= conv_start && conv_ok;
    end

    // R5: the error flag only drops on an explicit clear
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_err && !(ctrl_wr && ctrl_wdata[2])) |=> conv_err);

    // R10: conv_go only answers a request one cycle back
    assert_go_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> $past(conv_start));

endmodule

// File: rtl/hib_wake_ctrl.sv
module hib_wake_ctrl
    import hib_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SETTLE_NS = 110_000,
    parameter int unsigned AW        = 4,
    parameter int unsigned DW        = 8,
    parameter int unsigned CTRL_ADDR = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_wait,
    output logic          dom_sel,
    output logic          dom_write,
    output logic [AW-1:0] dom_addr,
    output logic [DW-1:0] dom_wdata,
    input  logic [DW-1:0] dom_rdata,
    output logic          wake_req,
    input  logic          wake_ready,
    input  logic          conv_start,
    output logic          conv_go,
    output logic          conv_err
);

    localparam longint unsigned PROD = longint'(SETTLE_NS) * longint'(CLK_HZ);
    localparam int unsigned SETTLE_CYC =
        int'((PROD + 64'd999_999_999) / 64'd1_000_000_000);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);

    hib_state_e state;
    logic       is_ctrl, dom_acc, ctrl_wr, hib_cmd;
    logic       settle_load, settle_busy, settle_last, conv_ok;
    logic [1:0] mode;

    assign is_ctrl = (bus_addr == CTRL_A);
    assign dom_acc = bus_req && !is_ctrl;
    assign ctrl_wr = bus_req && bus_write && is_ctrl;
    assign hib_cmd = ctrl_wr && (bus_wdata[1:0] == MODE_HIB);

    hib_wake_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .dom_acc     (dom_acc),
        .hib_cmd     (hib_cmd),
        .wake_ready  (wake_ready),
        .settle_last (settle_last),
        .state       (state),
        .bus_wait    (bus_wait),
        .wake_req    (wake_req),
        .settle_load (settle_load),
        .conv_ok     (conv_ok)
    );

    hib_settle_timer #(.CYCLES(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (settle_load),
        .busy  (settle_busy),
        .last  (settle_last)
    );

    hib_mode_conv u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (bus_wdata[2:0]),
        .conv_start (conv_start),
        .conv_ok    (conv_ok),
        .mode       (mode),
        .conv_err   (conv_err),
        .conv_go    (conv_go)
    );

    assign dom_sel   = dom_acc && !bus_wait;
    assign dom_write = bus_write;
    assign dom_addr  = bus_addr;
    assign dom_wdata = bus_wdata;
    assign bus_rdata = is_ctrl ? DW'({conv_err, mode}) : dom_rdata;

    // R2: no domain strobe reaches a sleeping domain
    assert_no_early_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dom_sel |-> (state == ST_ACTIVE || state == ST_SETTLING ||
                     (state == ST_WAKING && wake_ready)));

    // R3: mode field still holds hibernate when settling begins
    assert_mode_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLING && $past(state) == ST_WAKING && !$past(ctrl_wr))
            |-> (mode == MODE_HIB));

    // R4: ACTIVE never overlaps a running settle window
    assert_active_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE) |-> !settle_busy);

    // R4: a fired start never came from inside the window
    assert_go_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> $past(!settle_busy && state == ST_ACTIVE));

    // R9: control register accesses never stall
    assert_ctrl_nowait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && is_ctrl) |-> !bus_wait);

endmodule

// File: tb/hib_wake_ctrl_test.sv
module hib_wake_ctrl_test;

    localparam int unsigned CLK_HZ = 210_000;
    localparam int N_EXP = (110 * CLK_HZ + 999_999) / 1_000_000; // 24
    localparam logic [3:0] CTRL = 4'hF;

    logic       clk = 0, rst_n = 0;
    logic       bus_req = 0, bus_write = 0;
    logic [3:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata, dom_wdata, dom_rdata;
    logic       bus_wait, dom_sel, dom_write, wake_req, wake_ready = 0;
    logic [3:0] dom_addr;
    logic       conv_start = 0, conv_go, conv_err;

    int total = 0, bad = 0;
    int wake_delay = 1;
    int wcnt = 0;
    int wait_seen;
    logic wake_seen, ready_at_done;
    logic [7:0] exp_q[$];
    logic [7:0] dom_mem [16];

    always #5 clk = ~clk;

    hib_wake_ctrl #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait), .dom_sel(dom_sel), .dom_write(dom_write),
        .dom_addr(dom_addr), .dom_wdata(dom_wdata), .dom_rdata(dom_rdata),
        .wake_req(wake_req), .wake_ready(wake_ready), .conv_start(conv_start),
        .conv_go(conv_go), .conv_err(conv_err)
    );

    // domain register model
    assign dom_rdata = dom_mem[dom_addr];
    always @(posedge clk) if (dom_sel && dom_write) dom_mem[dom_addr] <= dom_wdata;

    // analog wake model: ready wake_delay cycles after wake_req rises
    initial forever begin
        @(posedge clk); #1;
        if (wake_req) begin
            wcnt++;
            wake_ready = (wcnt >= wake_delay);
        end else begin
            wcnt = 0;
            wake_ready = 0;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) chk(0, "R2 scoreboard leftover", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // scoreboard monitor: compares every completing read
    always @(negedge clk) begin
        if (rst_n && bus_req && !bus_write && !bus_wait) begin
            if (exp_q.size() == 0) chk(0, "R2 unexpected read", bus_rdata, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(bus_rdata == e, "R2/R3/R7 read data", bus_rdata, e);
            end
        end
    end

    task automatic bus_xfer(input logic wr, input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_req = 1; bus_write = wr; bus_addr = a; bus_wdata = d;
        wait_seen = 0; wake_seen = 0;
        forever begin
            @(negedge clk);
            if (wake_req) wake_seen = 1;
            if (!bus_wait) break;
            wait_seen++;
        end
        ready_at_done = wake_ready;
        @(posedge clk); #1;
        bus_req = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [7:0] e);
        exp_q.push_back(e);
        bus_xfer(0, a, 8'h00);
    endtask

    initial begin
        #2_000_000;
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) dom_mem[i] = 8'(i * 3);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R8: reset state
        chk(!bus_wait && !wake_req, "R8 idle after reset", {bus_wait, wake_req}, 0);
        chk(!conv_err, "R8 err clear", conv_err, 0);
        bus_rd(CTRL, 8'h01);                     // R8 mode active
        // R8, R10: start accepted at once, one-cycle pulse
        @(posedge clk); #1 conv_start = 1;
        @(posedge clk); #1 conv_start = 0;
        @(negedge clk); chk(conv_go, "R10 go pulse", conv_go, 1);
        @(negedge clk); chk(!conv_go, "R10 go single", conv_go, 0);

        // ACTIVE domain access: no wait
        bus_xfer(1, 4'h3, 8'hA5);
        chk(wait_seen == 0, "R9 active no wait", wait_seen, 0);
        bus_rd(4'h3, 8'hA5);

        // R9: enter hibernation, control access stays local
        bus_xfer(1, CTRL, 8'h02);
        bus_rd(CTRL, 8'h02);
        chk(wait_seen == 0 && !wake_seen, "R9 ctrl no wake", wait_seen, 0);

        // R1, R2, R7: dummy read wakes with delay 5
        wake_delay = 5;
        bus_rd(4'h3, 8'hA5);
        chk(wake_seen, "R1 wake_req raised", wake_seen, 1);
        chk(wait_seen == 5, "R2 wait cycles", wait_seen, 5);
        chk(ready_at_done, "R2 completes with ready", ready_at_done, 1);
        // R4/R5 boundary: cycle N-1 refused, cycle N accepted
        repeat (N_EXP - 1) @(posedge clk);
        #1 conv_start = 1;
        @(posedge clk);
        @(negedge clk);
        chk(!conv_go, "R4 last window cycle refused", conv_go, 0);
        chk(conv_err, "R5 err set", conv_err, 1);
        @(posedge clk); #1 conv_start = 0;
        @(negedge clk);
        chk(conv_go, "R4 first cycle after window accepted", conv_go, 1);
        // R3, R6, R7
        bus_rd(CTRL, 8'h06);                     // err=1, mode still hibernate
        bus_rd(4'h3, 8'hA5);                     // R7 data untouched
        bus_rd(4'h4, 8'h0C);                     // R7 neighbour untouched
        bus_xfer(1, CTRL, 8'h05);                // clear err, mode active
        bus_rd(CTRL, 8'h01);                     // R6, R3

        // R2: wake by write, ready on first waking cycle; R5 not queued
        bus_xfer(1, CTRL, 8'h02);
        wake_delay = 1;
        bus_xfer(1, 4'h5, 8'h3C);
        chk(wait_seen == 1, "R2 wait cycles d=1", wait_seen, 1);
        @(posedge clk); #1 conv_start = 1;
        @(posedge clk); #1 conv_start = 0;
        for (int k = 0; k < N_EXP + 4; k++) begin
            @(negedge clk);
            if (conv_go) chk(0, "R5 refused start queued", 1, 0);
        end
        chk(conv_err, "R5 err after write wake", conv_err, 1);
        bus_rd(4'h5, 8'h3C);                     // R2 write took effect
        bus_rd(CTRL, 8'h06);                     // R3 mode still hibernate
        finish_run();
    end

endmodule